// File: doc/BRIEF.md
# Phase-Accumulator Waveform Channel with Shadowed Phase Register

This block is a free-running counter channel that produces a timed pin waveform. It holds a 32-bit phase word and a 32-bit step word. On every clock that software does not write the phase, the step is added to the phase. Output edges can therefore be placed to a single clock. The pin output has two selectable forms. Oscillator mode gives a square wave taken from the top bit of the phase. Density mode gives a pulse train taken from the carry of each addition.

Software reaches the channel through a register port. A plain write loads either the phase or the step. A read returns the live phase or the step. A separate read-modify-write strobe changes the phase while the counter runs. A phase load always overrides the addition in that clock. It also copies the loaded value into a shadow register. A read-modify-write takes its operand from that shadow, not from the live count, and writes the result to both. Software can then shift the phase of a running counter by an exact number of clocks without any race against the counting. Nothing in the channel reloads phase or step by itself on a pin edge or on a wrap.

Top module: `phase_accum_chan`

## Requirements
- R1: In a clock with no phase load (no plain phase write and no read-modify-write), the phase register becomes its old value plus the step word, modulo 2^32.
- R2: A plain write with `reg_sel`=1 loads the step word. The addition in the same clock still uses the old step, and the new step is used from the next clock on.
- R3: A plain write with `reg_sel`=0 sets the phase register to `reg_wdata` exactly. No step is added in that clock.
- R4: Every phase load, whether a plain write or a read-modify-write, also stores the loaded value in the shadow register. The shadow does not follow the counting.
- R5: When `rmw_en`=1, the new phase is op(shadow, `rmw_data`). The op is set by `rmw_op`: 00 add, 01 subtract (shadow minus data), 10 bitwise AND, 11 bitwise OR. The result is written to the phase and to the shadow.
- R6: `rd_data` returns the live phase when `rd_sel`=0 and the step word when `rd_sel`=1, with no delay.
- R7: When `mode_sel`=0 (oscillator), after each clock `pin_out` equals bit 31 of the phase register.
- R8: When `mode_sel`=1 (density), after each clock `pin_out` equals the carry out of the 32-bit addition made in that clock. In a clock with a phase load it is 0.
- R9: If a plain phase write and a read-modify-write arrive in the same clock, the plain write wins and the read-modify-write is dropped, for both the phase and the shadow.
- R10: A synchronous active-high `rst` clears the phase, shadow, step and `pin_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Plain write strobe |
| reg_sel | input | 1 | Write target: 0 phase, 1 step |
| reg_wdata | input | 32 | Plain write data |
| rmw_en | input | 1 | Read-modify-write strobe on the phase |
| rmw_op | input | 2 | Read-modify-write operation code |
| rmw_data | input | 32 | Read-modify-write second operand |
| rd_sel | input | 1 | Read select: 0 live phase, 1 step |
| rd_data | output | 32 | Read data |
| mode_sel | input | 1 | Output form: 0 oscillator, 1 density |
| pin_out | output | 1 | Waveform output |

## Verification
Every register result is due one clock after the edge that samples the stimulus. This covers the phase, the shadow, the step and the registered `pin_out`. `rd_data` follows `rd_sel` with no delay. The bench drives inputs on the falling edge and updates its model just after the rising edge. It compares `rd_data` and `pin_out` at the next falling edge, so each check looks at the result of exactly one edge. Shadow contents cannot be read directly. The bench shows them by issuing a read-modify-write (OR with zero) and reading the phase one clock later.

// File: rtl/phacc_pkg.sv
package phacc_pkg;

    localparam int PH_W = 32;
    localparam int OP_W = 2;

    typedef logic [PH_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        RMW_ADD = 2'b00,
        RMW_SUB = 2'b01,
        RMW_AND = 2'b10,
        RMW_OR  = 2'b11
    } rmw_op_e;

    typedef enum logic {
        MODE_OSC  = 1'b0,
        MODE_DENS = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic  load;
        word_t value;
    } phase_load_t;

    typedef struct packed {
        logic  carry;
        word_t sum;
    } add_res_t;

    function automatic word_t rmw_apply(rmw_op_e op, word_t a, word_t b);
        case (op)
            RMW_ADD: return a + b;
            RMW_SUB: return a - b;
            RMW_AND: return a & b;
            default: return a | b;
        endcase
    endfunction

    function automatic add_res_t add_carry(word_t a, word_t b);
        add_res_t r;
        {r.carry, r.sum} = {1'b0, a} + {1'b0, b};
        return r;
    endfunction

endpackage

// File: rtl/phacc_wrdec.sv
module phacc_wrdec
    import phacc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  word_t               reg_wdata,
    input  logic                rmw_en,
    input  logic [OP_W-1:0]     rmw_op,
    input  word_t               rmw_data,
    output phase_load_t         ld,
    output word_t               shadow_q
);

    logic plain_ph;

    assign plain_ph = reg_wr && !reg_sel;

    always_comb begin
        ld.load  = 1'b0;
        ld.value = '0;
        if (plain_ph) begin
            ld.load  = 1'b1;
            ld.value = reg_wdata;
        end else if (rmw_en) begin
            ld.load  = 1'b1;
            ld.value = rmw_apply(rmw_op_e'(rmw_op), shadow_q, rmw_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (ld.load) begin
            shadow_q <= ld.value;
        end
    end

endmodule

// File: rtl/phacc_accum.sv
module phacc_accum
    import phacc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  phase_load_t ld,
    input  logic        freq_wr,
    input  word_t       freq_data,
    output word_t       phase_q,
    output word_t       phase_d,
    output word_t       freq_q,
    output logic        carry_now
);

    add_res_t step;

    always_comb begin
        step = add_carry(phase_q, freq_q);
        if (ld.load) begin
            phase_d   = ld.value;
            carry_now = 1'b0;
        end else begin
            phase_d   = step.sum;
            carry_now = step.carry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            freq_q  <= '0;
        end else begin
            phase_q <= phase_d;
            if (freq_wr) begin
                freq_q <= freq_data;
            end
        end
    end

endmodule

// File: rtl/phacc_pinsel.sv
module phacc_pinsel
    import phacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mode_sel,
    input  logic  top_bit_next,
    input  logic  carry_now,
    output logic  pin_q
);

    out_mode_e mode;

    assign mode = out_mode_e'(mode_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else begin
            case (mode)
                MODE_OSC:  pin_q <= top_bit_next;
                default:   pin_q <= carry_now;
            endcase
        end
    end

endmodule

// File: rtl/phase_accum_chan.sv
module phase_accum_chan
    import phacc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  logic [PH_W-1:0]     reg_wdata,
    input  logic                rmw_en,
    input  logic [OP_W-1:0]     rmw_op,
    input  logic [PH_W-1:0]     rmw_data,
    input  logic                rd_sel,
    output logic [PH_W-1:0]     rd_data,
    input  logic                mode_sel,
    output logic                pin_out
);

    phase_load_t ld;
    word_t       shadow_q;
    word_t       phase_q;
    word_t       phase_d;
    word_t       freq_q;
    logic        carry_now;

    phacc_wrdec u_dec (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .rmw_en    (rmw_en),
        .rmw_op    (rmw_op),
        .rmw_data  (rmw_data),
        .ld        (ld),
        .shadow_q  (shadow_q)
    );

    phacc_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .ld        (ld),
        .freq_wr   (reg_wr && reg_sel),
        .freq_data (reg_wdata),
        .phase_q   (phase_q),
        .phase_d   (phase_d),
        .freq_q    (freq_q),
        .carry_now (carry_now)
    );

    phacc_pinsel u_pin (
        .clk          (clk),
        .rst          (rst),
        .mode_sel     (mode_sel),
        .top_bit_next (phase_d[PH_W-1]),
        .carry_now    (carry_now),
        .pin_q        (pin_out)
    );

    assign rd_data = rd_sel ? freq_q : phase_q;

endmodule

// File: rtl/phacc_chk.sv
module phacc_chk
    import phacc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [PH_W-1:0]  reg_wdata,
    input logic             rmw_en,
    input logic [OP_W-1:0]  rmw_op,
    input logic [PH_W-1:0]  rmw_data,
    input logic             mode_sel,
    input logic             pin_out,
    input logic [PH_W-1:0]  phase_q,
    input logic [PH_W-1:0]  freq_q,
    input logic [PH_W-1:0]  shadow_q
);

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (phase_q == '0 && shadow_q == '0 && freq_q == '0 && !pin_out));

    p_count_r1: assert property (@(posedge clk) disable iff (rst)
        (!(reg_wr && !reg_sel) && !rmw_en) |=> phase_q == $past(phase_q) + $past(freq_q));

    p_step_load_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel) |=> freq_q == $past(reg_wdata));

    p_write_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel) |=> phase_q == $past(reg_wdata));

    p_shadow_load_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel) |=> shadow_q == $past(reg_wdata));

    p_rmw_result_r5: assert property (@(posedge clk) disable iff (rst)
        (rmw_en && !(reg_wr && !reg_sel)) |=>
            (phase_q == rmw_apply(rmw_op_e'($past(rmw_op)), $past(shadow_q), $past(rmw_data))
             && shadow_q == phase_q));

    p_osc_pin_r7: assert property (@(posedge clk) disable iff (rst)
        !mode_sel |=> pin_out == phase_q[PH_W-1]);

    p_dens_load_low_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_sel && ((reg_wr && !reg_sel) || rmw_en)) |=> !pin_out);

endmodule

bind phase_accum_chan phacc_chk u_chk (.*);

// File: tb/sim_phase_accum_chan.sv
module sim_phase_accum_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        rmw_en = 1'b0;
    logic [1:0]  rmw_op = '0;
    logic [31:0] rmw_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        mode_sel = 1'b0;
    logic        pin_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_phase, m_shadow, m_freq;
    logic        m_pin;

    always #4 clk = ~clk;

    phase_accum_chan u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rmw_en(rmw_en), .rmw_op(rmw_op),
        .rmw_data(rmw_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .mode_sel(mode_sel), .pin_out(pin_out)
    );

    function automatic logic [31:0] ref_op(logic [1:0] op, logic [31:0] a, logic [31:0] b);
        if (op == 2'b00) return a + b;
        if (op == 2'b01) return a - b;
        if (op == 2'b10) return a & b;
        return a | b;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic        ld;
        logic [31:0] val;
        logic [32:0] s;
        ld  = 1'b0;
        val = '0;
        if (reg_wr && !reg_sel) begin
            ld = 1'b1; val = reg_wdata;
        end else if (rmw_en) begin
            ld = 1'b1; val = ref_op(rmw_op, m_shadow, rmw_data);
        end
        s = {1'b0, m_phase} + {1'b0, m_freq};
        if (ld) begin
            m_phase = val; m_shadow = val;
            m_pin = mode_sel ? 1'b0 : val[31];
        end else begin
            m_phase = s[31:0];
            m_pin = mode_sel ? s[32] : s[31];
        end
        if (reg_wr && reg_sel) m_freq = reg_wdata;
    endtask

    // one clock: drive now (falling edge), model after rising edge, check at next falling edge
    task automatic cyc(logic wr, logic sel, logic [31:0] wd, logic rmw, logic [1:0] op,
                       logic [31:0] rd, logic mode, logic rs, string tag_rd, string tag_pin);
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        rmw_en = rmw; rmw_op = op; rmw_data = rd;
        mode_sel = mode; rd_sel = rs;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        chk(tag_rd, rd_data, rs ? m_freq : m_phase);
        chk(tag_pin, {31'd0, pin_out}, {31'd0, m_pin});
    endtask

    task automatic idle(int n, logic mode, string tag_rd, string tag_pin);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, mode, 0, tag_rd, tag_pin);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        reg_wr = 0; rmw_en = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_phase = '0; m_shadow = '0; m_freq = '0; m_pin = 1'b0;
        rd_sel = 0; #0;
        chk("R10 phase", rd_data, 32'd0);
        chk("R10 pin", {31'd0, pin_out}, 32'd0);
        rd_sel = 1; #1;
        chk("R10 step", rd_data, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // step write: old step (0) still used in this clock
        cyc(1, 1, 32'h1000_0000, 0, 0, 0, 0, 1, "R2 step readback", "R7 osc pin");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R2 new step used next clock", "R7 osc pin");
        idle(8, 0, "R1 accumulate", "R7 osc pin top bit");
        // plain phase write overrides addition
        cyc(1, 0, 32'h0000_0100, 0, 0, 0, 0, 0, "R3 phase write exact", "R7 osc pin");
        idle(3, 0, "R6 live read", "R7 osc pin");
        // RMW add uses shadow, not live count
        cyc(0, 0, 0, 1, 2'b00, 32'd5, 0, 0, "R5 rmw add from shadow", "R7 osc pin");
        chk("R4 shadow from write", rd_data, 32'h0000_0105);
        idle(2, 0, "R1 accumulate", "R7 osc pin");
        cyc(0, 0, 0, 1, 2'b11, 32'd0, 0, 0, "R4 shadow after rmw", "R7 osc pin");
        chk("R4 shadow holds rmw result", rd_data, 32'h0000_0105);
        cyc(0, 0, 0, 1, 2'b01, 32'd6, 0, 0, "R5 rmw sub", "R7 osc pin");
        cyc(0, 0, 0, 1, 2'b10, 32'hFFFF_FF0F, 0, 0, "R5 rmw and", "R7 osc pin");
        // same-clock write and rmw: write wins
        cyc(1, 0, 32'h0000_2000, 1, 2'b00, 32'd7, 0, 0, "R9 write beats rmw", "R7 osc pin");
        chk("R9 phase", rd_data, 32'h0000_2000);
        cyc(0, 0, 0, 1, 2'b11, 32'd0, 0, 0, "R9 shadow is write value", "R7 osc pin");
        chk("R9 shadow", rd_data, 32'h0000_2000);
        // density mode
        cyc(1, 1, 32'h4000_0000, 0, 0, 0, 1, 1, "R2 step write", "R8 dens pin");
        cyc(1, 0, 32'hC000_0000, 0, 0, 0, 1, 0, "R3 phase write", "R8 dens pin low on load");
        chk("R8 load clock pin", {31'd0, pin_out}, 32'd0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R1 wrap", "R8 carry");
        chk("R8 carry on wrap", {31'd0, pin_out}, 32'd1);
        idle(6, 1, "R1 accumulate", "R8 dens pin");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic wr, rmw, mode;
            wr   = ($urandom_range(0, 7) == 0);
            rmw  = ($urandom_range(0, 7) == 0);
            mode = (i / 500) % 2 == 1;
            cyc(wr, 1'($urandom_range(0, 1)), $urandom(), rmw, 2'($urandom_range(0, 3)),
                $urandom(), mode, 1'($urandom_range(0, 1)), "R6 random read",
                mode ? "R8 random pin" : "R7 random pin");
        end

        do_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule